// File: doc/BRIEF.md
# Interlace-Aware Composite Sync Generator

This block builds the synchronisation waveforms for a standard-definition raster at the usual 15.6 kHz line rate. A single pixel-rate enable drives a horizontal position counter and a half-line counter. From these two counters it produces separate horizontal and vertical sync, a field flag, and a composite sync. The composite sync is not the XOR of the other two. In the vertical interval of every field it carries a run of narrow equalizing pulses at each half line. These are followed by a run of serrated broad pulses and then a second run of equalizing pulses.

The two field types differ in where the vertical interval begins. A field of type 0 starts its interval on a line boundary. A field of type 1 starts it half a line later, at mid-line. In interlaced operation the type alternates from field to field, and each field lasts an odd number of half lines. In progressive operation a selected field type is repeated for ever, and each field lasts one half line fewer. A request to change mode takes effect only at the start of a frame, so the vertical interval is never malformed. In interlaced operation a frame starts at a type-0 field. In progressive operation every field is a frame.

Top module: `csync_gen`

## Requirements
- R1: While reset is held, and after its release until the first enabled pixel, the position is the start of a type-0 field. csync_n=0 (first equalizing pulse), hsync_n=0, vsync_n=1 and field=0.
- R2: hsync_n is low for the first HSYNC_W enabled pixels of every line of H_TOTAL pixels, in every mode and in every field.
- R3: Outside the vertical interval, csync_n is low only during the HSYNC_W pixels at the start of a line. No pulse appears at mid-line.
- R4: Each field opens with NEQ half lines whose csync_n is low for EQ_W pixels from the half-line start. Then come NBR half lines low for H_TOTAL/2-SERR_W pixels, then NEQ more half lines of EQ_W-pixel pulses.
- R5: vsync_n is low exactly during the NBR broad-pulse half lines of each field.
- R6: The field output is 0 for a field whose first half line starts at horizontal position 0, and 1 for one that starts at position H_TOTAL/2. It changes only at a field start.
- R7: With the interlace input high (1 = interlaced), fields alternate 0,1,0,1. Each field is LINES half lines long (LINES odd), so a frame is LINES lines.
- R8: With the interlace input low, every field has the type given by the field-select input (0 or 1) and is LINES-1 half lines long. The field output stays constant.
- R9: The mode inputs are sampled only at a field start that is also a frame start: a type-0 field start in interlaced mode, or any field start in progressive mode. A field in which the type must change lasts LINES half lines.
- R10: When the pixel enable is low, no counter advances and no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Pixel-rate enable; one raster position per enabled cycle |
| ilace_en | input | 1 | 1 = interlaced (alternating fields), 0 = progressive |
| prog_field | input | 1 | Field type repeated in progressive mode |
| csync_n | output | 1 | Composite sync, active low, with equalizing and serrated broad pulses |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low during the broad pulses |
| field | output | 1 | Type of the current field (0 line-start, 1 mid-line start) |

## Verification
Two actions can fall on the same cycle: the wrap of the half-line counter into a new field, and the sampling of the mode inputs, together with the choice of the new field's length. The bench changes the interlace and field-select inputs part-way through a field, in both directions. It expects the old pattern to run on to the next frame boundary and the new pattern to start exactly there. It also gates the pixel enable with a fixed irregular pattern, so that stalls land on half-line and field boundaries. Each output is compared every enabled pixel against a pattern computed from the elapsed pixel count.

// File: rtl/csg_pkg.sv
package csg_pkg;

    // Which part of a field the current half line belongs to
    typedef enum logic [1:0] {
        SEG_PRE_EQ,
        SEG_BROAD,
        SEG_POST_EQ,
        SEG_ACTIVE
    } seg_e;

    // Latched operating mode
    typedef struct packed {
        logic interlace;   // 1: alternate field types
        logic odd_sel;     // progressive: field type to repeat
    } vmode_t;

    // Classify a half-line index within a field
    function automatic seg_e seg_of(int idx, int neq, int nbr);
        if (idx < neq)
            return SEG_PRE_EQ;
        else if (idx < neq + nbr)
            return SEG_BROAD;
        else if (idx < 2 * neq + nbr)
            return SEG_POST_EQ;
        return SEG_ACTIVE;
    endfunction

    // Length in half lines of a field that starts with phase start_mid,
    // chosen so the following field starts with the phase the mode wants
    function automatic int field_span(vmode_t m, logic start_mid, int lines);
        logic next_mid;
        next_mid = m.interlace ? ~start_mid : m.odd_sel;
        return (next_mid != start_mid) ? lines : lines - 1;
    endfunction

endpackage

// File: rtl/csg_line_timer.sv
module csg_line_timer #(
    parameter int H_TOTAL = 1024,
    localparam int HW = $clog2(H_TOTAL)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pix_en,
    output logic [HW-1:0] h,
    output logic          hl_step,
    output logic          hl_mid
);
    localparam logic [HW-1:0] LAST = HW'(H_TOTAL - 1);
    localparam logic [HW-1:0] HALF = HW'(H_TOTAL / 2);

    logic [HW-1:0] h_nx;

    always_comb begin
        h_nx = (h == LAST) ? '0 : h + 1'b1;
    end

    // A half line begins when the next position is 0 or the mid-line point
    assign hl_step = pix_en && ((h_nx == '0) || (h_nx == HALF));
    assign hl_mid  = (h_nx == HALF);

    always_ff @(posedge clk) begin
        if (rst)
            h <= '0;
        else if (pix_en)
            h <= h_nx;
    end
endmodule

// File: rtl/csg_field_seq.sv
module csg_field_seq
    import csg_pkg::*;
#(
    parameter int LINES = 625,
    parameter int NEQ   = 5,
    parameter int NBR   = 5,
    localparam int LW   = $clog2(LINES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic          step_mid,
    input  vmode_t        mode_in,
    output logic [LW-1:0] hl,
    output logic          field,
    output seg_e          seg,
    output vmode_t        mode_q
);
    logic [LW-1:0] span;
    logic          wrap;
    logic          take;
    vmode_t        m_new;

    always_comb begin
        wrap  = (hl == span - 1'b1);
        // A new frame begins at a line-start field, or at any field when progressive
        take  = !step_mid || !mode_q.interlace;
        m_new = take ? mode_in : mode_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hl     <= '0;
            field  <= 1'b0;
            mode_q <= mode_in;
            span   <= LW'(field_span(mode_in, 1'b0, LINES));
        end else if (step) begin
            if (wrap) begin
                hl     <= '0;
                field  <= step_mid;
                mode_q <= m_new;
                span   <= LW'(field_span(m_new, step_mid, LINES));
            end else begin
                hl <= hl + 1'b1;
            end
        end
    end

    assign seg = seg_of(int'(hl), NEQ, NBR);
endmodule

// File: rtl/csg_pulse_shaper.sv
module csg_pulse_shaper
    import csg_pkg::*;
#(
    parameter int H_TOTAL = 1024,
    parameter int HSYNC_W = 75,
    parameter int EQ_W    = 38,
    parameter int SERR_W  = 75,
    localparam int HW     = $clog2(H_TOTAL)
) (
    input  logic [HW-1:0] h,
    input  seg_e          seg,
    output logic          csync_n,
    output logic          hsync_n,
    output logic          vsync_n
);
    localparam logic [HW-1:0] HALF = HW'(H_TOTAL / 2);
    localparam logic [HW-1:0] HS   = HW'(HSYNC_W);
    localparam logic [HW-1:0] EQ   = HW'(EQ_W);
    localparam logic [HW-1:0] BRL  = HW'(H_TOTAL / 2 - SERR_W);

    logic [HW-1:0] hp;
    logic          line_pulse;
    logic          low;

    always_comb begin
        hp         = (h >= HALF) ? h - HALF : h;
        line_pulse = (h < HS);
        unique case (seg)
            SEG_PRE_EQ,
            SEG_POST_EQ: low = (hp < EQ);
            SEG_BROAD:   low = (hp < BRL);
            default:     low = line_pulse;
        endcase
        csync_n = ~low;
        hsync_n = ~line_pulse;
        vsync_n = (seg != SEG_BROAD);
    end
endmodule

// File: rtl/csync_gen.sv
module csync_gen
    import csg_pkg::*;
#(
    parameter int H_TOTAL = 1024,
    parameter int HSYNC_W = 75,
    parameter int EQ_W    = 38,
    parameter int SERR_W  = 75,
    parameter int LINES   = 625,
    parameter int NEQ     = 5,
    parameter int NBR     = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic pix_en,
    input  logic ilace_en,
    input  logic prog_field,
    output logic csync_n,
    output logic hsync_n,
    output logic vsync_n,
    output logic field
);
    localparam int HW = $clog2(H_TOTAL);
    localparam int LW = $clog2(LINES + 1);

    logic [HW-1:0] h_cnt;
    logic [LW-1:0] hl_cnt;
    logic          hl_step;
    logic          hl_mid;
    seg_e          seg;
    vmode_t        mode_req;
    vmode_t        mode_q;

    assign mode_req = '{interlace: ilace_en, odd_sel: prog_field};

    csg_line_timer #(.H_TOTAL(H_TOTAL)) u_line (
        .clk     (clk),
        .rst     (rst),
        .pix_en  (pix_en),
        .h       (h_cnt),
        .hl_step (hl_step),
        .hl_mid  (hl_mid)
    );

    csg_field_seq #(.LINES(LINES), .NEQ(NEQ), .NBR(NBR)) u_field (
        .clk      (clk),
        .rst      (rst),
        .step     (hl_step),
        .step_mid (hl_mid),
        .mode_in  (mode_req),
        .hl       (hl_cnt),
        .field    (field),
        .seg      (seg),
        .mode_q   (mode_q)
    );

    csg_pulse_shaper #(
        .H_TOTAL (H_TOTAL),
        .HSYNC_W (HSYNC_W),
        .EQ_W    (EQ_W),
        .SERR_W  (SERR_W)
    ) u_shape (
        .h       (h_cnt),
        .seg     (seg),
        .csync_n (csync_n),
        .hsync_n (hsync_n),
        .vsync_n (vsync_n)
    );
endmodule

// File: rtl/csg_chk.sv
module csg_chk #(
    parameter int H_TOTAL = 1024,
    parameter int HSYNC_W = 75,
    parameter int LINES   = 625,
    parameter int NEQ     = 5,
    localparam int HW     = $clog2(H_TOTAL),
    localparam int LW     = $clog2(LINES + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          pix_en,
    input logic [HW-1:0] h,
    input logic [LW-1:0] hl,
    input logic          mode_il,
    input logic          field,
    input logic          csync_n,
    input logic          hsync_n,
    input logic          vsync_n
);
    localparam logic [HW-1:0] HALF = HW'(H_TOTAL / 2);
    localparam logic [HW-1:0] HS   = HW'(HSYNC_W);
    localparam logic [LW-1:0] EQN  = LW'(NEQ);
    localparam logic [LW-1:0] LN   = LW'(LINES);

    // R2: horizontal sync ends after HSYNC_W pixels
    p_hs_width_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(hsync_n) |-> (h == HS));

    // R4: a broad pulse covers the line-start sync window
    p_broad_cover_r4: assert property (@(posedge clk) disable iff (rst)
        (!vsync_n && !hsync_n) |-> !csync_n);

    // R5: vertical sync begins right after the pre-equalizing run
    p_vs_start_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(vsync_n) |-> (hl == EQN));

    // R6: field type matches the phase at which the field starts
    p_field_phase_r6: assert property (@(posedge clk) disable iff (rst)
        (field != $past(field)) |-> ((hl == '0) && (h == (field ? HALF : '0))));

    // R7: the half-line index stays inside the longest field
    p_span_r7: assert property (@(posedge clk) disable iff (rst)
        hl < LN);

    // R9: latched mode only moves when a new field begins
    p_mode_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (hl != '0) |-> $stable(mode_il));

    // R10: outputs freeze while the pixel enable is low
    p_stall_r10: assert property (@(posedge clk) disable iff (rst)
        !pix_en |=> ($stable(csync_n) && $stable(hsync_n) &&
                     $stable(vsync_n) && $stable(field)));
endmodule

bind csync_gen csg_chk #(
    .H_TOTAL (H_TOTAL),
    .HSYNC_W (HSYNC_W),
    .LINES   (LINES),
    .NEQ     (NEQ)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .pix_en  (pix_en),
    .h       (h_cnt),
    .hl      (hl_cnt),
    .mode_il (mode_q.interlace),
    .field   (field),
    .csync_n (csync_n),
    .hsync_n (hsync_n),
    .vsync_n (vsync_n)
);

// File: tb/csync_gen_bench.sv
module csync_gen_bench;
    localparam int HT  = 40;
    localparam int HH  = HT / 2;
    localparam int HS  = 6;
    localparam int EQW = 3;
    localparam int SW  = 6;
    localparam int LN  = 25;
    localparam int NEQ = 5;
    localparam int NBR = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pix_en = 1'b0;
    logic ilace_en = 1'b1;
    logic prog_field = 1'b0;
    logic csync_n, hsync_n, vsync_n, field;

    int n_chk = 0;
    int n_bad = 0;
    int t = 0;
    int cyc = 0;

    csync_gen #(
        .H_TOTAL (HT), .HSYNC_W (HS), .EQ_W (EQW), .SERR_W (SW),
        .LINES (LN), .NEQ (NEQ), .NBR (NBR)
    ) u_csync_gen (
        .clk (clk), .rst (rst), .pix_en (pix_en),
        .ilace_en (ilace_en), .prog_field (prog_field),
        .csync_n (csync_n), .hsync_n (hsync_n),
        .vsync_n (vsync_n), .field (field)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s t=%0d actual=%b expected=%b", req, what, t, act, exp);
        end
    endtask

    // mode 0: interlaced from a type-0 field; 1: progressive type 0;
    // 2: progressive type 1 entered from a type-0 field
    function automatic void expect_at(input int mode, input int tt, input int habs,
                                      output logic cs, output logic hs,
                                      output logic vs, output logic fl);
        int f, u, hl, hp, h, tf;
        logic low;
        case (mode)
            0: begin
                tf = tt % (LN * HT);
                if (tf < LN * HH) begin f = 0; u = tf; end
                else begin f = 1; u = tf - LN * HH; end
            end
            1: begin f = 0; u = tt % ((LN - 1) * HH); end
            default: begin
                if (tt < LN * HH) begin f = 0; u = tt; end
                else begin f = 1; u = (tt - LN * HH) % ((LN - 1) * HH); end
            end
        endcase
        hl = u / HH;
        hp = u % HH;
        h  = habs % HT;
        if (hl < NEQ) low = (hp < EQW);
        else if (hl < NEQ + NBR) low = (hp < HH - SW);
        else if (hl < 2 * NEQ + NBR) low = (hp < EQW);
        else low = (h < HS);
        cs = !low;
        hs = !(h < HS);
        vs = !((hl >= NEQ) && (hl < NEQ + NBR));
        fl = (f != 0);
    endfunction

    task automatic tick_cmp(input int mode, input int base, input string req);
        logic ecs, ehs, evs, efl, en;
        @(negedge clk);
        expect_at(mode, t - base, t, ecs, ehs, evs, efl);
        chk({"R3/R4 ", req}, "csync_n", csync_n, ecs);
        chk("R2", "hsync_n", hsync_n, ehs);
        chk("R5", "vsync_n", vsync_n, evs);
        chk({"R6 ", req}, "field", field, efl);
        en = (cyc % 3) != 1;
        pix_en = en;
        @(posedge clk);
        if (en) t++;
    endtask

    task automatic do_reset(input logic il, input logic sel);
        @(negedge clk);
        rst = 1'b1;
        pix_en = 1'b0;
        ilace_en = il;
        prog_field = sel;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t = 0;
    endtask

    task automatic test_reset();
        do_reset(1'b1, 1'b0);
        #1;
        chk("R1", "csync_n", csync_n, 1'b0);
        chk("R1", "hsync_n", hsync_n, 1'b0);
        chk("R1", "vsync_n", vsync_n, 1'b1);
        chk("R1", "field", field, 1'b0);
    endtask

    task automatic test_interlaced();
        do_reset(1'b1, 1'b0);
        while (t < 2 * LN * HT) tick_cmp(0, 0, "R7");
    endtask

    task automatic test_prog_even();
        do_reset(1'b0, 1'b0);
        while (t < 3 * (LN - 1) * HH + 50) tick_cmp(1, 0, "R8");
    endtask

    task automatic test_prog_odd();
        do_reset(1'b0, 1'b1);
        while (t < LN * HH + 3 * (LN - 1) * HH) tick_cmp(2, 0, "R8/R9");
    endtask

    task automatic test_mode_switch();
        int t2;
        do_reset(1'b1, 1'b0);
        // request progressive type 1 in the middle of the second field
        while (t < LN * HH + 30) tick_cmp(0, 0, "R9");
        ilace_en = 1'b0;
        prog_field = 1'b1;
        // old interlaced frame must finish unchanged
        while (t < LN * HT) tick_cmp(0, 0, "R9");
        // back to interlaced while inside a progressive type-1 field
        while (t < LN * HT + LN * HH + 100) tick_cmp(2, LN * HT, "R9");
        ilace_en = 1'b1;
        t2 = LN * HT + LN * HH + (LN - 1) * HH;
        while (t < t2) tick_cmp(2, LN * HT, "R9");
        while (t < t2 + 2 * LN * HT) tick_cmp(0, t2 - LN * HH, "R9/R7");
    endtask

    task automatic test_stall();
        logic c0, h0, v0, f0;
        do_reset(1'b1, 1'b0);
        while (t < 137) tick_cmp(0, 0, "R10");
        @(negedge clk);
        pix_en = 1'b0;
        c0 = csync_n; h0 = hsync_n; v0 = vsync_n; f0 = field;
        repeat (40) begin
            @(negedge clk);
            chk("R10", "csync_n", csync_n, c0);
            chk("R10", "hsync_n", hsync_n, h0);
            chk("R10", "vsync_n", vsync_n, v0);
            chk("R10", "field", field, f0);
        end
        while (t < 700) tick_cmp(0, 0, "R10");
    endtask

    initial begin
        test_reset();
        test_interlaced();
        test_prog_even();
        test_prog_odd();
        test_mode_switch();
        test_stall();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired at t=%0d actual=running expected=done", t);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule